// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block holds the 8-bit power control register of a small microcontroller and turns its contents into the enables the rest of the chip needs. Software writes and reads the register over a simple special-function-register bus. The block then gates the CPU clock and the system clock, and holds Timer 2, the PWM unit and the ADC while the chip is idle. It also runs or stops the oscillators in power-down and forces the external bus pins (ALE, PSEN, port 0) to their low-power states.

Entry into Idle or Power-down is a register write. The block leaves Idle when an enabled interrupt arrives. It leaves Power-down only on an external interrupt or a reset. The watchdog load-enable flag clears itself when the watchdog timer reports a load. The baud-doubling flag, the aux-RAM-disable flag and the load-enable flag are brought out as plain outputs for the peripherals that use them.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the register holds 0x00. A read (`bus_rd`=1) at address 0x87 returns the register on `bus_rdata`, in the same cycle. A read at any other address, or no read at all, returns 0x00.
- R2: A write at address 0x87 stores all eight data bits from the next clock edge. The one exception is the rule in R3. A write at any other address leaves the register unchanged.
- R3: Bit 1 (power-down) is stored as 1 only if `pd_allow` is high in the write cycle. Otherwise it is stored as 0.
- R4: Bit 4 (watchdog load enable) is 0 after any edge at which `wdt_loaded` is high. This holds even if the same cycle writes a 1 to that bit. The bit is mirrored on `wdt_load_en`.
- R5: While bit 0 (idle) is 1 and bit 1 is 0, the block is in Idle mode. In Idle, `cpu_clk_en`=0 and `sys_clk_en`=1, and `t2_rst`, `pwm_rst`, `pwm_force_high` and `adc_abort` are all 1. In run mode and in Power-down, those four outputs are 0.
- R6: If `irq_wake` is high in Idle, bit 0 is 0 after the next edge. The CPU clock enable returns to 1 at that edge. This wake takes priority over a write in the same cycle. `irq_wake` has no effect in Power-down.
- R7: While bit 1 is 1, `sys_clk_en`=0 and `cpu_clk_en`=0. In this mode `hf_osc_run` = NOT `sel_hf`, and `osc32_run` = (NOT `sel_hf`) AND `run32`. Outside Power-down, both oscillator outputs are 1.
- R8: If `ext_wake` is high in Power-down, bits 1 and 0 are both 0 after the next edge. This wake takes priority over a write in the same cycle.
- R9: In Idle or Power-down, `ale_force_high` and `psen_force_high` are 1, and `p0_hiz` equals `code_ext`. In run mode all three are 0.
- R10: Bit 5 sets `ale_hold` only in run mode. In Idle and Power-down, `ale_hold` is 0.
- R11: Bit 7 drives `baud_dbl` and bit 6 drives `aux_ram_dis`. Bits 3 and 2 are plain storage that reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pd_allow | input | 1 | External enable for power-down entry |
| wdt_loaded | input | 1 | Watchdog timer was loaded this cycle |
| irq_wake | input | 1 | Enabled interrupt pending |
| ext_wake | input | 1 | External interrupt pending |
| sel_hf | input | 1 | HF oscillator selected (0 = PLL source) |
| run32 | input | 1 | Keep the 32 kHz oscillator running in power-down |
| code_ext | input | 1 | Code fetched from external memory |
| cpu_clk_en | output | 1 | CPU clock gate |
| sys_clk_en | output | 1 | System clock gate |
| t2_rst | output | 1 | Timer 2 stop and reset |
| pwm_rst | output | 1 | PWM reset |
| pwm_force_high | output | 1 | PWM outputs forced high |
| adc_abort | output | 1 | Abort ADC conversion |
| hf_osc_run | output | 1 | HF oscillator run |
| osc32_run | output | 1 | 32 kHz oscillator run |
| ale_hold | output | 1 | Suppress ALE toggling |
| ale_force_high | output | 1 | Drive ALE high |
| psen_force_high | output | 1 | Drive PSEN high |
| p0_hiz | output | 1 | Port 0 to high impedance |
| baud_dbl | output | 1 | Serial baud doubling |
| aux_ram_dis | output | 1 | Internal aux RAM disabled |
| wdt_load_en | output | 1 | Watchdog load enable flag |

## Verification
Register effects show one rising edge after their stimulus: writes, the self-clear of the load-enable flag, and both wake-ups. Every decoded output and the read data follow the register and the current inputs in the same cycle, with no further delay. The bench updates a behavioural model of the register on each rising edge from the inputs held during that cycle. One nanosecond after each falling edge, it compares every output with values derived from the model and the present inputs. Inputs change only at those points, so each comparison sees exactly one register update.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    // Field order fixes the bit positions that software relies on.
    typedef struct packed {
        logic smod;   // bit 7: baud doubling
        logic ard;    // bit 6: aux RAM disable
        logic rfi;    // bit 5: ALE quiet
        logic wle;    // bit 4: watchdog load enable
        logic gf1;    // bit 3: spare flag
        logic gf0;    // bit 2: spare flag
        logic pd;     // bit 1: power-down
        logic idl;    // bit 0: idle
    } pcon_t;

    localparam int PCON_W = $bits(pcon_t);

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } pmode_e;

endpackage

// File: rtl/pwr_pcon_reg.sv
module pwr_pcon_reg
    import pwr_mode_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PCON_W-1:0] bus_wdata,
    input  logic              pd_allow,
    input  logic              wdt_loaded,
    input  logic              irq_wake,
    input  logic              ext_wake,
    output pcon_t             pcon
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    pcon_t pcon_d, pcon_q;
    logic  wr_hit;

    assign wr_hit = bus_wr && (bus_addr == HIT_ADDR);

    always_comb begin
        pcon_d = pcon_q;
        if (wr_hit) begin
            pcon_d    = pcon_t'(bus_wdata);
            pcon_d.pd = bus_wdata[1] & pd_allow;
        end
        if (wdt_loaded) begin
            pcon_d.wle = 1'b0;
        end
        if (pcon_q.pd) begin
            if (ext_wake) begin
                pcon_d.pd  = 1'b0;
                pcon_d.idl = 1'b0;
            end
        end else if (pcon_q.idl && irq_wake) begin
            pcon_d.idl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcon_q <= '0;
        else        pcon_q <= pcon_d;
    end

    assign pcon = pcon_q;

    AST_PD_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcon_q.pd) |-> $past(pd_allow));                              // R3
    AST_WLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_loaded |=> !pcon_q.wle);                                        // R4
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pcon_q.idl && !pcon_q.pd && irq_wake) |=> !pcon_q.idl);            // R6
    AST_PD_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pcon_q.pd && !ext_wake && !wr_hit) |=> pcon_q.pd);                 // R6
    AST_PD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pcon_q.pd && ext_wake) |=> (!pcon_q.pd && !pcon_q.idl));           // R8

endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
    import pwr_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pcon_t pcon,
    input  logic  sel_hf,
    input  logic  run32,
    input  logic  code_ext,
    output logic  cpu_clk_en,
    output logic  sys_clk_en,
    output logic  t2_rst,
    output logic  pwm_rst,
    output logic  pwm_force_high,
    output logic  adc_abort,
    output logic  hf_osc_run,
    output logic  osc32_run,
    output logic  ale_hold,
    output logic  ale_force_high,
    output logic  psen_force_high,
    output logic  p0_hiz,
    output logic  baud_dbl,
    output logic  aux_ram_dis,
    output logic  wdt_load_en
);

    pmode_e mode;

    always_comb begin
        if (pcon.pd)       mode = MODE_PDOWN;
        else if (pcon.idl) mode = MODE_IDLE;
        else               mode = MODE_RUN;
    end

    always_comb begin
        cpu_clk_en      = 1'b1;
        sys_clk_en      = 1'b1;
        t2_rst          = 1'b0;
        pwm_rst         = 1'b0;
        pwm_force_high  = 1'b0;
        adc_abort       = 1'b0;
        hf_osc_run      = 1'b1;
        osc32_run       = 1'b1;
        ale_hold        = 1'b0;
        ale_force_high  = 1'b0;
        psen_force_high = 1'b0;
        p0_hiz          = 1'b0;
        unique case (mode)
            MODE_RUN: begin
                ale_hold = pcon.rfi;
            end
            MODE_IDLE: begin
                cpu_clk_en      = 1'b0;
                t2_rst          = 1'b1;
                pwm_rst         = 1'b1;
                pwm_force_high  = 1'b1;
                adc_abort       = 1'b1;
                ale_force_high  = 1'b1;
                psen_force_high = 1'b1;
                p0_hiz          = code_ext;
            end
            MODE_PDOWN: begin
                cpu_clk_en      = 1'b0;
                sys_clk_en      = 1'b0;
                hf_osc_run      = !sel_hf;
                osc32_run       = !sel_hf && run32;
                ale_force_high  = 1'b1;
                psen_force_high = 1'b1;
                p0_hiz          = code_ext;
            end
            default: ;
        endcase
    end

    assign baud_dbl    = pcon.smod;
    assign aux_ram_dis = pcon.ard;
    assign wdt_load_en = pcon.wle;

    AST_OSC32_ONLY_PDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !osc32_run |-> !sys_clk_en);                                        // R7
    AST_P0_HIZ_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
        p0_hiz |-> (psen_force_high && !cpu_clk_en));                       // R9
    AST_IDLE_KEEPS_SYSCLK: assert property (@(posedge clk) disable iff (!rst_n)
        t2_rst |-> (sys_clk_en && !cpu_clk_en));                            // R5
    AST_ALE_HOLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ale_hold |-> !ale_force_high);                                      // R10

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] REG_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              pd_allow,
    input  logic              wdt_loaded,
    input  logic              irq_wake,
    input  logic              ext_wake,
    input  logic              sel_hf,
    input  logic              run32,
    input  logic              code_ext,
    output logic              cpu_clk_en,
    output logic              sys_clk_en,
    output logic              t2_rst,
    output logic              pwm_rst,
    output logic              pwm_force_high,
    output logic              adc_abort,
    output logic              hf_osc_run,
    output logic              osc32_run,
    output logic              ale_hold,
    output logic              ale_force_high,
    output logic              psen_force_high,
    output logic              p0_hiz,
    output logic              baud_dbl,
    output logic              aux_ram_dis,
    output logic              wdt_load_en
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    pcon_t pcon;

    pwr_pcon_reg #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) i_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .pd_allow   (pd_allow),
        .wdt_loaded (wdt_loaded),
        .irq_wake   (irq_wake),
        .ext_wake   (ext_wake),
        .pcon       (pcon)
    );

    pwr_out_decode i_dec (
        .clk             (clk),
        .rst_n           (rst_n),
        .pcon            (pcon),
        .sel_hf          (sel_hf),
        .run32           (run32),
        .code_ext        (code_ext),
        .cpu_clk_en      (cpu_clk_en),
        .sys_clk_en      (sys_clk_en),
        .t2_rst          (t2_rst),
        .pwm_rst         (pwm_rst),
        .pwm_force_high  (pwm_force_high),
        .adc_abort       (adc_abort),
        .hf_osc_run      (hf_osc_run),
        .osc32_run       (osc32_run),
        .ale_hold        (ale_hold),
        .ale_force_high  (ale_force_high),
        .psen_force_high (psen_force_high),
        .p0_hiz          (p0_hiz),
        .baud_dbl        (baud_dbl),
        .aux_ram_dis     (aux_ram_dis),
        .wdt_load_en     (wdt_load_en)
    );

    assign bus_rdata = (bus_rd && bus_addr == HIT_ADDR) ? pcon : '0;

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));                                  // R1

endmodule

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       pd_allow = 0, wdt_loaded = 0, irq_wake = 0, ext_wake = 0;
    logic       sel_hf = 0, run32 = 0, code_ext = 0;
    logic       cpu_clk_en, sys_clk_en, t2_rst, pwm_rst, pwm_force_high, adc_abort;
    logic       hf_osc_run, osc32_run, ale_hold, ale_force_high, psen_force_high;
    logic       p0_hiz, baud_dbl, aux_ram_dis, wdt_load_en;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] ref_q;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (.*);

    // Behavioural reference of the register, from the requirements.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= 8'h00;
        else begin
            automatic logic [7:0] n = ref_q;
            if (bus_wr && bus_addr == 8'h87) begin            // R2
                n = bus_wdata;
                if (!pd_allow) n[1] = 1'b0;                   // R3
            end
            if (wdt_loaded) n[4] = 1'b0;                      // R4
            if (ref_q[1]) begin
                if (ext_wake) begin n[1] = 1'b0; n[0] = 1'b0; end  // R8
            end else if (ref_q[0] && irq_wake) n[0] = 1'b0;   // R6
            ref_q <= n;
        end
    end

    task automatic chk(string name, string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, name, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        automatic logic pd   = ref_q[1];
        automatic logic idl  = ref_q[0] && !ref_q[1];
        automatic logic lowp = ref_q[0] || ref_q[1];
        chk("rdata", "R1", bus_rdata, (bus_rd && bus_addr == 8'h87) ? ref_q : 8'h00);
        chk("cpu_clk_en", "R5", cpu_clk_en, !lowp);
        chk("sys_clk_en", "R7", sys_clk_en, !pd);
        chk("t2_rst", "R5", t2_rst, idl);
        chk("pwm_rst", "R5", pwm_rst, idl);
        chk("pwm_force_high", "R5", pwm_force_high, idl);
        chk("adc_abort", "R5", adc_abort, idl);
        chk("hf_osc_run", "R7", hf_osc_run, !(pd && sel_hf));
        chk("osc32_run", "R7", osc32_run, !pd || (!sel_hf && run32));
        chk("ale_force_high", "R9", ale_force_high, lowp);
        chk("psen_force_high", "R9", psen_force_high, lowp);
        chk("p0_hiz", "R9", p0_hiz, lowp && code_ext);
        chk("ale_hold", "R10", ale_hold, ref_q[5] && !lowp);
        chk("baud_dbl", "R11", baud_dbl, ref_q[7]);
        chk("aux_ram_dis", "R11", aux_ram_dis, ref_q[6]);
        chk("wdt_load_en", "R4", wdt_load_en, ref_q[4]);
    endtask

    // Advance one cycle; compare 1 ns after the falling edge.
    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            compare_all();
        end
    endtask

    task automatic clear_strobes();
        bus_wr = 0; bus_rd = 0; wdt_loaded = 0; irq_wake = 0; ext_wake = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        clear_strobes();
    endtask

    task automatic rd(logic [7:0] a);
        bus_rd = 1; bus_addr = a;
        #0.5; compare_all();                  // same-cycle read data, R1
        cyc();
        clear_strobes();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1; compare_all();                    // R1 reset state
        rst_n = 1;
        cyc(2);
        rd(8'h87);
        // R2 and R11: store all fields, read back spare flags
        wr(8'h87, 8'hEC); rd(8'h87); cyc();
        wr(8'h86, 8'hFF); rd(8'h87);          // R2 other address ignored
        rd(8'h88);
        // R4: load enable clears on watchdog load, even against a write
        wr(8'h87, 8'h10); cyc();
        wdt_loaded = 1; cyc(); clear_strobes(); cyc();
        wr(8'h87, 8'h10);
        bus_wr = 1; bus_addr = 8'h87; bus_wdata = 8'h10; wdt_loaded = 1;
        cyc(); clear_strobes(); rd(8'h87);
        // R3: power-down refused without allow
        pd_allow = 0; wr(8'h87, 8'h02); rd(8'h87);
        // R5, R9, R10: idle with ALE quiet bit set, both code sources
        wr(8'h87, 8'h21); code_ext = 1; cyc(2); code_ext = 0; cyc(2);
        rd(8'h87);
        // R6: interrupt wakes idle
        irq_wake = 1; cyc(); clear_strobes(); cyc();
        // R6: wake beats a same-cycle write
        wr(8'h87, 8'h01);
        bus_wr = 1; bus_addr = 8'h87; bus_wdata = 8'h01; irq_wake = 1;
        cyc(); clear_strobes(); cyc();
        // R7, R8, R9: power-down with each oscillator choice
        pd_allow = 1; sel_hf = 1; run32 = 1; code_ext = 1;
        wr(8'h87, 8'h03); cyc(2);
        irq_wake = 1; cyc(2); clear_strobes();   // R6 ignored in power-down
        sel_hf = 0; run32 = 1; cyc(2);
        run32 = 0; cyc(2);
        code_ext = 0; cyc();
        ext_wake = 1; cyc(); clear_strobes(); cyc();
        rd(8'h87);
        // R8: external wake beats a same-cycle write
        wr(8'h87, 8'h02);
        bus_wr = 1; bus_addr = 8'h87; bus_wdata = 8'h02; ext_wake = 1;
        cyc(); clear_strobes(); cyc();
        // R8: ext_wake outside power-down does nothing; idle remains
        wr(8'h87, 8'h01); ext_wake = 1; cyc(); clear_strobes(); cyc();
        irq_wake = 1; cyc(); clear_strobes();
        // R10 in run mode, R11 mirrors
        wr(8'h87, 8'hE0); cyc(2);
        wr(8'h87, 8'h00); cyc(2);
        // reset mid-operation returns to R1 state
        wr(8'h87, 8'hFF); cyc();
        rst_n = 0; #1; compare_all();
        cyc(); rst_n = 1; cyc(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule